// File: doc/BRIEF.md
# GPIO Bank Pin Register Block

This block is one 32-pin general-purpose I/O bank. It sits behind a simple 32-bit register bus and holds two pieces of pin state: a direction word and an output latch. A processor sets and clears output bits through two write-only alias addresses. Each alias acts only on the bits written as one, so no read-modify-write sequence is needed and two agents cannot lose each other's updates.

The pad inputs go through a two-stage synchronizer and are captured into a readable input word. A fixed revision word lets software identify the block. The block drives two vectors to the pads: the output values and a per-pin drive enable. Pad muxing, pulls, debounce, wake-up and interrupt detection are handled elsewhere.

The bus uses word addresses: the byte offset divided by four. A read issued with `rd_en` in one cycle returns its data on `rd_data` in the next cycle. The block has no state machine. Its only sequencing is the input synchronizer pipeline and the one-cycle read register.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the direction word is all ones, the output latch is all zeros, and both `pad_oe` and `pad_out` are zero.
- R2: The direction word sits at byte offset 0x134 (word 0x4D) and reads back what was written. A bit of 1 makes that pin an input, and a bit of 0 makes it an output. `pad_oe[n]` is the inverse of direction bit n from the cycle after the write.
- R3: A write to byte offset 0x13C (word 0x4F) replaces all 32 latch bits. The latch reads back at that offset, and `pad_out` shows the new value from the cycle after the write.
- R4: A write to byte offset 0x194 (word 0x65) sets every latch bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: A write to byte offset 0x190 (word 0x64) clears every latch bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R6: The input word at byte offset 0x138 (word 0x4E) shows `pad_in` after two synchronizer flops and one capture flop. A pad change applied before clock edge k is readable in the word after edge k+2, and not before.
- R7: The revision word at byte offset 0x000 always reads 0x50600801.
- R8: Any address outside the revision, direction, input and latch words reads zero. This includes the two write-only aliases. A write to an unmapped address changes neither the direction word nor the latch.
- R9: `rd_data` carries the addressed word in the cycle after `rd_en`, and is zero in any cycle that follows a cycle without `rd_en`.
- R10: Writes to the revision word or to the input word have no effect on what those words read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output latch driven to the pads |
| pad_oe | output | 32 | Per-pin drive enable, 1 = driving |

## Verification
The hardest case to reach from the ports is the exact latency of the input path. A read that lands one cycle too early must still return the old pad value. The stimulus changes `pad_in` between edges and issues one read that samples before the capture flop updates and another that samples just after it. Both values are checked. The alias checks chain set and clear writes on top of a non-trivial latch pattern, so that bits which must be left alone are ones in some places and zeros in others.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Word addresses (byte offset / 4)
    localparam int unsigned W_REVISION = 'h000;
    localparam int unsigned W_DIR      = 'h04D;
    localparam int unsigned W_DIN      = 'h04E;
    localparam int unsigned W_DOUT     = 'h04F;
    localparam int unsigned W_CLR      = 'h064;
    localparam int unsigned W_SET      = 'h065;

    localparam logic [31:0] REVISION_WORD = 32'h5060_0801;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] din_q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= pad_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= stage_q[STAGES-1];
    end

    // R6: the capture flop follows the last synchronizer stage one cycle later
    a_r6_capture_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(stage_q[STAGES-1]) |=> (din_q == $past(stage_q[STAGES-1])));
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_dout,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    logic [WIDTH-1:0] lat_d;

    always_comb begin
        lat_d = lat_q;
        if (wr_dout) lat_d = wdata;
        if (wr_set)  lat_d = lat_d | wdata;
        if (wr_clr)  lat_d = lat_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            lat_q <= lat_d;
        end
    end

    // R4: set alias forces the ones and keeps the rest
    a_r4_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr && !wr_dout) |=>
            ((lat_q & $past(wdata)) == $past(wdata)) &&
            ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

    // R5: clear alias drops the ones and keeps the rest
    a_r5_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set && !wr_dout) |=>
            ((lat_q & $past(wdata)) == '0) &&
            ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

    // R8: without a latch write strobe the latch holds
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr || wr_dout) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  din_q,
    input  logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (addr == ADDR_W'(W_REVISION)) sel_word = WIDTH'(REVISION_WORD);
        if (addr == ADDR_W'(W_DIR))      sel_word = dir_q;
        if (addr == ADDR_W'(W_DIN))      sel_word = din_q;
        if (addr == ADDR_W'(W_DOUT))     sel_word = lat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
        else            rd_data <= '0;
    end

    // R9: an idle cycle leaves the read bus at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R7: a revision read always returns the constant
    a_r7_revision: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(W_REVISION)) |=> (rd_data == WIDTH'(REVISION_WORD)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic             wr_dir, wr_dout, wr_set, wr_clr;
    logic [WIDTH-1:0] dir_q, lat_q, din_q;

    always_comb begin
        wr_dir  = wr_en && (addr == ADDR_W'(W_DIR));
        wr_dout = wr_en && (addr == ADDR_W'(W_DOUT));
        wr_set  = wr_en && (addr == ADDR_W'(W_SET));
        wr_clr  = wr_en && (addr == ADDR_W'(W_CLR));
    end

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .din_q  (din_q)
    );

    gpio_out_regs #(.WIDTH(WIDTH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_dout (wr_dout),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q)
    );

    gpio_rd_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .dir_q   (dir_q),
        .din_q   (din_q),
        .lat_q   (lat_q),
        .rd_data (rd_data)
    );

    assign pad_out = lat_q;
    assign pad_oe  = ~dir_q;

    // R2: a direction write sets the drive enables to its inverse
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(W_DIR)) |=> (pad_oe == ~$past(wdata)));

    // R3: a direct latch write appears on the pads
    a_r3_dout_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(W_DOUT)) |=> (pad_out == $past(wdata)));

    // R8: an unmapped write disturbs neither pad vector
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_W'(W_DIR) && addr != ADDR_W'(W_DOUT) &&
         addr != ADDR_W'(W_SET) && addr != ADDR_W'(W_CLR))
            |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;

    // {op, word addr, data or expected, requirement number}
    localparam logic [49:0] VEC [NVEC] = '{
        {OP_RD, 8'h00, 32'h5060_0801, 8'd7},  // R7 revision
        {OP_RD, 8'h4D, 32'hFFFF_FFFF, 8'd1},  // R1 direction reset
        {OP_RD, 8'h4F, 32'h0000_0000, 8'd1},  // R1 latch reset
        {OP_WR, 8'h4F, 32'hA5A5_0F0F, 8'd3},  // R3 direct write
        {OP_RD, 8'h4F, 32'hA5A5_0F0F, 8'd3},
        {OP_WR, 8'h65, 32'h0000_F0F0, 8'd4},  // R4 set alias
        {OP_RD, 8'h4F, 32'hA5A5_FFFF, 8'd4},
        {OP_WR, 8'h64, 32'hFF00_000F, 8'd5},  // R5 clear alias
        {OP_RD, 8'h4F, 32'h00A5_FFF0, 8'd5},
        {OP_WR, 8'h65, 32'h0000_0000, 8'd4},  // R4 zero data leaves latch
        {OP_RD, 8'h4F, 32'h00A5_FFF0, 8'd4},
        {OP_WR, 8'h64, 32'h0000_0000, 8'd5},  // R5 zero data leaves latch
        {OP_RD, 8'h4F, 32'h00A5_FFF0, 8'd5},
        {OP_WR, 8'h4D, 32'h0F0F_0000, 8'd2},  // R2 direction write
        {OP_RD, 8'h4D, 32'h0F0F_0000, 8'd2},
        {OP_WR, 8'h70, 32'hDEAD_BEEF, 8'd8},  // R8 unmapped write
        {OP_RD, 8'h4F, 32'h00A5_FFF0, 8'd8},
        {OP_RD, 8'h4D, 32'h0F0F_0000, 8'd8},
        {OP_RD, 8'h70, 32'h0000_0000, 8'd8},  // R8 unmapped read
        {OP_RD, 8'h65, 32'h0000_0000, 8'd8},  // R8 alias reads zero
        {OP_WR, 8'h00, 32'h0000_0000, 8'd10}, // R10 revision write
        {OP_RD, 8'h00, 32'h5060_0801, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, pad_in = '0;
    logic [31:0] rd_data, pad_out, pad_oe;
    int checks = 0, fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input int req, input logic [31:0] exp_v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp_v);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, pad_oe, 32'h0);   // R1 no pin driving
        check(1, pad_out, 32'h0);  // R1 latch clear

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][49:48] == OP_WR)
                do_write(VEC[i][47:40], VEC[i][39:8]);
            else
                do_read(VEC[i][47:40], int'(VEC[i][7:0]), VEC[i][39:8]);
        end

        check(2, pad_oe, 32'hF0F0_FFFF);  // R2 inverse of direction
        check(3, pad_out, 32'h00A5_FFF0); // R3 pads follow latch

        // R9 idle cycle returns zero
        @(negedge clk);
        check(9, rd_data, 32'h0);

        // R6 input latency: change before edge k, visible after edge k+2
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);              // edge k: first stage
        rd_en = 1'b1; addr = 8'h4E;
        @(negedge clk);              // edge k+1: read sees old capture
        rd_en = 1'b0;
        check(6, rd_data, 32'h0);
        rd_en = 1'b1;                // edge k+2 captures and read samples old
        @(negedge clk);
        rd_en = 1'b0;
        check(6, rd_data, 32'h0);
        do_read(8'h4E, 6, 32'h1234_5678);

        // R10 write to input word is ignored
        do_write(8'h4E, 32'hFFFF_0000);
        do_read(8'h4E, 10, 32'h1234_5678);

        // R4 / R5 on a driving pin pattern seen at the pads
        do_write(8'h65, 32'hFF00_0000);
        check(4, pad_out, 32'hFFA5_FFF0);
        do_write(8'h64, 32'h0000_FFFF);
        check(5, pad_out, 32'hFFA5_0000);

        // R1 reset reapplied restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, pad_oe, 32'h0);
        do_read(8'h4D, 1, 32'hFFFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule